// File: doc/BRIEF.md
# Keyed Watchdog Timer with Register Port

This block is a memory-mapped watchdog. Software reaches it through a 32-bit, word-only register port: a byte address, a write strobe, write data and combinational read data. While the watchdog is enabled, a down-counter steps down once on every cycle in which the external 1 MHz tick-enable input is high. Software keeps the system alive by writing a fixed 16-bit key to a dedicated restart register. This copies the programmed reload value back into the counter.

When the counter runs out, the block can do two things, each enabled by its own control bit. It can raise a sticky interrupt. It can also drive a system reset pulse, whose length is counted in ticks. The pulse polarity and the pad drive type are changed only by writing a magic byte to the top of the pulse register. The drive type is only reported on a status pin. An input from the memory controller can veto the expiry action. In that case nothing fires, and the control register is wiped.

Top module: `kwdt_top`

## Requirements
- R1: After reset, the counter (0x00) and the reload value (0x04) both read 0x014FB180, control (0x0C) reads 0x00000010, the pulse register (0x18) reads 0x000000FF, the interrupt is low, the drive-type output is 0, and the reset output is at its idle level (high, because the pulse is active-low).
- R2: Offset 0x00 returns the live counter and ignores writes. Offset 0x04 is read/write. Offset 0x08 reads 0. Offset 0x1C is plain 32-bit storage. Any other offset reads 0 and ignores writes.
- R3: A write to 0x08 whose low 16 bits are 0x4755 loads the reload value into the counter, clears the interrupt, and runs the countdown if control bit 0 is set. Any other value written there changes nothing.
- R4: Control bit 0 is the enable, bit 1 arms the reset pulse and bit 2 arms the interrupt. Bits 3 (external reset enable) and 5 (reset mode) are stored only. On every control write, bit 4 is forced to 1 and bits 11:8 are forced to 0. All other bits are stored as written.
- R5: A control write that takes bit 0 from 0 to 1 loads the reload value and starts counting. A write that takes it from 1 to 0 stops counting and clears the interrupt. A write that leaves bit 0 unchanged leaves the counter alone.
- R6: The counter moves only while it is running and the tick input is high. A tick seen with the counter at 1 or 0 is the expiry. It leaves the counter at 0 and halts the countdown. A reload of 0 therefore expires on the first tick.
- R7: An expiry with control bit 2 set makes the interrupt output high. It stays high until a valid restart or a disable.
- R8: An expiry with control bit 1 set drives the reset output to its active level for (bits 19:0 of 0x18) + 1 ticks, counted from the expiry. The output then returns to idle. Bit 31 of 0x18 set means active-high, and clear means active-low.
- R9: A write to 0x18 always loads bits 19:0. Top byte 0xA5 sets bit 31 and 0x5A clears it. Top byte 0xA8 sets bit 30 and 0x8A clears it. Any other top byte leaves bits 31:30 as they were. All other bits read 0.
- R10: The drive-type output follows bit 30 of 0x18: 1 means push-pull and 0 means open-drain.
- R11: If the memory-controller hold input is high at expiry, there is no reset pulse and no interrupt. The countdown stops and the control register becomes 0x00000000.
- R12: A valid restart write in the same cycle as the expiring tick wins. The counter is reloaded and keeps running, and neither the interrupt nor the reset pulse fires.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| tick_1us | input | 1 | 1 MHz tick enable, high for one clock per tick |
| memctl_hold | input | 1 | Vetoes the expiry action when high |
| wdt_irq | output | 1 | Sticky expiry interrupt |
| sys_rst_out | output | 1 | System reset pulse, polarity per bit 31 of 0x18 |
| rst_push_pull | output | 1 | Drive-type status, 1 for push-pull |

## Verification
The countdown can reach its expiring tick in the same cycle that software's restart write lands. That collision decides whether the system is reset. The bench steps the counter down to 1. It then raises the write strobe with the key and the tick input on the same clock edge. It judges the outcome at the ports: the counter must read back the reload value, the interrupt must stay low and the reset output must stay idle. One further tick must then move the counter, which shows the countdown kept running. The veto input is exercised in the same way, with an expiry while it is high. The checks are that control reads zero and that neither output moves.

// File: rtl/kwdt_pkg.sv
package kwdt_pkg;

   // Register byte offsets (word aligned)
   localparam int OFS_COUNT   = 'h00;
   localparam int OFS_RELOAD  = 'h04;
   localparam int OFS_RESTART = 'h08;
   localparam int OFS_CTRL    = 'h0C;
   localparam int OFS_PULSE   = 'h18;
   localparam int OFS_MASK    = 'h1C;

   localparam logic [15:0] RESTART_KEY = 16'h4755;

   // Top-byte codes for the pulse register
   localparam logic [7:0] CODE_POL_HIGH = 8'hA5;
   localparam logic [7:0] CODE_POL_LOW  = 8'h5A;
   localparam logic [7:0] CODE_PUSHPULL = 8'hA8;
   localparam logic [7:0] CODE_OPENDRN  = 8'h8A;

   // Control bit positions
   localparam int CB_EN     = 0;
   localparam int CB_RST    = 1;
   localparam int CB_IRQ    = 2;
   localparam int CB_EXT    = 3;
   localparam int CB_TICK   = 4;
   localparam int CB_MODE   = 5;

   // Pulse register flag positions
   localparam int PB_POL    = 31;
   localparam int PB_DRIVE  = 30;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_RELOAD,
      SEL_RESTART,
      SEL_CTRL,
      SEL_PULSE,
      SEL_MASK,
      SEL_COUNT
   } reg_sel_e;

endpackage

// File: rtl/kwdt_regs.sv
module kwdt_regs
   import kwdt_pkg::*;
#(
   parameter int          ADDR_W      = 8,
   parameter int          DATA_W      = 32,
   parameter int          CNT_W       = 32,
   parameter int          PW_W        = 20,
   parameter logic [31:0] RELOAD_INIT = 32'h014F_B180,
   parameter logic [31:0] PW_INIT     = 32'h0000_00FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr_i,
   input  logic              we_i,
   input  logic [DATA_W-1:0] wdata_i,
   output logic [DATA_W-1:0] rdata_o,
   input  logic [CNT_W-1:0]  cnt_i,
   input  logic              hold_clr_i,
   output logic [CNT_W-1:0]  reload_o,
   output logic              en_o,
   output logic              rst_en_o,
   output logic              irq_en_o,
   output logic [PW_W-1:0]   pw_o,
   output logic              pol_hi_o,
   output logic              push_pull_o,
   output logic              restart_o,
   output logic              arm_o,
   output logic              stop_o
);

   localparam logic [DATA_W-1:0] CTRL_CLR = DATA_W'(32'h0000_0F00);
   localparam logic [DATA_W-1:0] CTRL_SET = DATA_W'(32'h0000_0010);
   localparam int                TOP_LSB  = DATA_W - 8;

   reg_sel_e          sel;
   logic [CNT_W-1:0]  reload_q;
   logic [DATA_W-1:0] ctrl_q;
   logic [DATA_W-1:0] mask_q;
   logic [PW_W-1:0]   pw_q;
   logic              pol_q;
   logic              pp_q;
   logic [DATA_W-1:0] ctrl_san;
   logic [7:0]        top_byte;
   logic              ctrl_wr;
   logic              pulse_wr;

   // Address decode: exact word match, anything else selects nothing
   always_comb begin
      if (addr_i == ADDR_W'(OFS_COUNT))        sel = SEL_COUNT;
      else if (addr_i == ADDR_W'(OFS_RELOAD))  sel = SEL_RELOAD;
      else if (addr_i == ADDR_W'(OFS_RESTART)) sel = SEL_RESTART;
      else if (addr_i == ADDR_W'(OFS_CTRL))    sel = SEL_CTRL;
      else if (addr_i == ADDR_W'(OFS_PULSE))   sel = SEL_PULSE;
      else if (addr_i == ADDR_W'(OFS_MASK))    sel = SEL_MASK;
      else                                     sel = SEL_NONE;
   end

   assign ctrl_san = (wdata_i & ~CTRL_CLR) | CTRL_SET;
   assign top_byte = wdata_i[DATA_W-1:TOP_LSB];
   assign ctrl_wr  = we_i && (sel == SEL_CTRL);
   assign pulse_wr = we_i && (sel == SEL_PULSE);

   // Strobes toward the countdown
   assign restart_o = we_i && (sel == SEL_RESTART) && (wdata_i[15:0] == RESTART_KEY);
   assign arm_o     = ctrl_wr &&  ctrl_san[CB_EN] && !ctrl_q[CB_EN];
   assign stop_o    = ctrl_wr && !ctrl_san[CB_EN] &&  ctrl_q[CB_EN];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         reload_q <= RELOAD_INIT[CNT_W-1:0];
         ctrl_q   <= CTRL_SET;
         mask_q   <= '0;
         pw_q     <= PW_INIT[PW_W-1:0];
         pol_q    <= PW_INIT[PB_POL];
         pp_q     <= PW_INIT[PB_DRIVE];
      end else begin
         if (we_i && (sel == SEL_RELOAD)) reload_q <= wdata_i[CNT_W-1:0];
         if (we_i && (sel == SEL_MASK))   mask_q   <= wdata_i;
         if (hold_clr_i)                  ctrl_q   <= '0;
         else if (ctrl_wr)                ctrl_q   <= ctrl_san;
         if (pulse_wr) begin
            pw_q <= wdata_i[PW_W-1:0];
            unique case (top_byte)
               CODE_POL_HIGH: pol_q <= 1'b1;
               CODE_POL_LOW:  pol_q <= 1'b0;
               CODE_PUSHPULL: pp_q  <= 1'b1;
               CODE_OPENDRN:  pp_q  <= 1'b0;
               default: ;
            endcase
         end
      end
   end

   // Read-back view of the pulse register and the counter
   logic [DATA_W-1:0] pulse_view;
   logic [DATA_W-1:0] cnt_view;
   always_comb begin
      pulse_view                = '0;
      pulse_view[PW_W-1:0]      = pw_q;
      pulse_view[PB_POL]        = pol_q;
      pulse_view[PB_DRIVE]      = pp_q;
      cnt_view                  = '0;
      cnt_view[CNT_W-1:0]       = cnt_i;
   end

   logic [DATA_W-1:0] reload_view;
   always_comb begin
      reload_view              = '0;
      reload_view[CNT_W-1:0]   = reload_q;
   end

   always_comb begin
      unique case (sel)
         SEL_COUNT:  rdata_o = cnt_view;
         SEL_RELOAD: rdata_o = reload_view;
         SEL_CTRL:   rdata_o = ctrl_q;
         SEL_PULSE:  rdata_o = pulse_view;
         SEL_MASK:   rdata_o = mask_q;
         default:    rdata_o = '0;
      endcase
   end

   assign reload_o    = reload_q;
   assign en_o        = ctrl_q[CB_EN];
   assign rst_en_o    = ctrl_q[CB_RST];
   assign irq_en_o    = ctrl_q[CB_IRQ];
   assign pw_o        = pw_q;
   assign pol_hi_o    = pol_q;
   assign push_pull_o = pp_q;

   // R4
   ctrl_sanitize_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ctrl_wr && !hold_clr_i) |=> (ctrl_q[CB_TICK] && ctrl_q[11:8] == 4'h0));

   // R11
   hold_wipe_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_clr_i |=> (ctrl_q == '0));

   // R10
   drive_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pp_q) |-> $past(pulse_wr));

   // R9
   pol_change_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !$stable(pol_q) |-> $past(pulse_wr));

endmodule

// File: rtl/kwdt_count.sv
module kwdt_count #(
   parameter int          CNT_W      = 32,
   parameter logic [31:0] COUNT_INIT = 32'h014F_B180
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick_i,
   input  logic             restart_i,
   input  logic             arm_i,
   input  logic             stop_i,
   input  logic             en_i,
   input  logic             irq_arm_i,
   input  logic [CNT_W-1:0] reload_i,
   output logic [CNT_W-1:0] cnt_o,
   output logic             expire_o,
   output logic             irq_o
);

   localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

   logic [CNT_W-1:0] cnt_q;
   logic             run_q;
   logic             irq_q;
   logic             load;
   logic             expire;

   assign load   = restart_i | arm_i;
   assign expire = run_q & tick_i & ~load & ~stop_i & (cnt_q <= ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= COUNT_INIT[CNT_W-1:0];
         run_q <= 1'b0;
         irq_q <= 1'b0;
      end else begin
         if (load) begin
            cnt_q <= reload_i;
            run_q <= arm_i | en_i;
         end else if (stop_i) begin
            run_q <= 1'b0;
         end else if (expire) begin
            cnt_q <= '0;
            run_q <= 1'b0;
         end else if (run_q && tick_i) begin
            cnt_q <= cnt_q - ONE;
         end

         if (restart_i || stop_i)       irq_q <= 1'b0;
         else if (expire && irq_arm_i)  irq_q <= 1'b1;
      end
   end

   assign cnt_o    = cnt_q;
   assign expire_o = expire;
   assign irq_o    = irq_q;

   // R6
   step_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (run_q && tick_i && !load && !stop_i && cnt_q > ONE) |=> (cnt_q == $past(cnt_q) - ONE));

   // R6
   no_tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!tick_i && !load) |=> $stable(cnt_q));

   // R6
   halt_after_exp_chk: assert property (@(posedge clk) disable iff (!rst_n)
      expire |=> (!run_q && cnt_q == '0));

   // R3
   restart_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart_i |=> (cnt_q == $past(reload_i) && !irq_q));

   // R7
   irq_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(irq_q) |-> $past(restart_i || stop_i));

endmodule

// File: rtl/kwdt_pulse.sv
module kwdt_pulse #(
   parameter int PW_W = 20
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            tick_i,
   input  logic            fire_i,
   input  logic [PW_W-1:0] width_i,
   input  logic            pol_hi_i,
   output logic            rst_o
);

   logic [PW_W-1:0] left_q;
   logic            act_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q <= '0;
         act_q  <= 1'b0;
      end else if (fire_i) begin
         left_q <= width_i;
         act_q  <= 1'b1;
      end else if (act_q && tick_i) begin
         if (left_q == '0) act_q  <= 1'b0;
         else              left_q <= left_q - PW_W'(1);
      end
   end

   // Active level follows the polarity flag; idle is its complement
   assign rst_o = act_q ? pol_hi_i : ~pol_hi_i;

   // R8
   pulse_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(act_q) |-> $past(fire_i));

   // R8
   pulse_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !tick_i && !fire_i) |=> act_q);

endmodule

// File: rtl/kwdt_top.sv
module kwdt_top #(
   parameter int          ADDR_W      = 8,
   parameter int          DATA_W      = 32,
   parameter int          CNT_W       = 32,
   parameter int          PW_W        = 20,
   parameter logic [31:0] COUNT_INIT  = 32'h014F_B180,
   parameter logic [31:0] PW_INIT     = 32'h0000_00FF
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic              bus_we,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              tick_1us,
   input  logic              memctl_hold,
   output logic              wdt_irq,
   output logic              sys_rst_out,
   output logic              rst_push_pull
);

   // Elaboration-time parameter checks
   if (DATA_W != 32) begin : g_bad_data_w
      $error("kwdt_top: DATA_W must be 32");
   end
   if (ADDR_W < 5) begin : g_bad_addr_w
      $error("kwdt_top: ADDR_W must reach offset 0x1C");
   end
   if (CNT_W < 2 || CNT_W > DATA_W) begin : g_bad_cnt_w
      $error("kwdt_top: CNT_W out of range");
   end
   if (PW_W < 1 || PW_W > DATA_W - 8) begin : g_bad_pw_w
      $error("kwdt_top: PW_W overlaps the code byte");
   end

   logic [CNT_W-1:0] reload;
   logic [CNT_W-1:0] cnt;
   logic [PW_W-1:0]  pw;
   logic             en, rst_en, irq_en, pol_hi;
   logic             restart, arm, stop, expire;
   logic             fire, irq_arm, hold_clr;

   assign fire     = expire & rst_en & ~memctl_hold;
   assign irq_arm  = irq_en & ~memctl_hold;
   assign hold_clr = expire & memctl_hold;

   kwdt_regs #(
      .ADDR_W      (ADDR_W),
      .DATA_W      (DATA_W),
      .CNT_W       (CNT_W),
      .PW_W        (PW_W),
      .RELOAD_INIT (COUNT_INIT),
      .PW_INIT     (PW_INIT)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .addr_i      (bus_addr),
      .we_i        (bus_we),
      .wdata_i     (bus_wdata),
      .rdata_o     (bus_rdata),
      .cnt_i       (cnt),
      .hold_clr_i  (hold_clr),
      .reload_o    (reload),
      .en_o        (en),
      .rst_en_o    (rst_en),
      .irq_en_o    (irq_en),
      .pw_o        (pw),
      .pol_hi_o    (pol_hi),
      .push_pull_o (rst_push_pull),
      .restart_o   (restart),
      .arm_o       (arm),
      .stop_o      (stop)
   );

   kwdt_count #(
      .CNT_W      (CNT_W),
      .COUNT_INIT (COUNT_INIT)
   ) u_count (
      .clk       (clk),
      .rst_n     (rst_n),
      .tick_i    (tick_1us),
      .restart_i (restart),
      .arm_i     (arm),
      .stop_i    (stop),
      .en_i      (en),
      .irq_arm_i (irq_arm),
      .reload_i  (reload),
      .cnt_o     (cnt),
      .expire_o  (expire),
      .irq_o     (wdt_irq)
   );

   kwdt_pulse #(
      .PW_W (PW_W)
   ) u_pulse (
      .clk      (clk),
      .rst_n    (rst_n),
      .tick_i   (tick_1us),
      .fire_i   (fire),
      .width_i  (pw),
      .pol_hi_i (pol_hi),
      .rst_o    (sys_rst_out)
   );

   // R11
   veto_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      hold_clr |=> ($stable(sys_rst_out) && !$rose(wdt_irq)));

   // R12
   restart_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
      restart |-> !expire);

endmodule

// File: tb/kwdt_top_tb_top.sv
module kwdt_top_tb_top;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [7:0]  bus_addr = '0;
   logic        bus_we = 1'b0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        tick_1us = 1'b0;
   logic        memctl_hold = 1'b0;
   logic        wdt_irq;
   logic        sys_rst_out;
   logic        rst_push_pull;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #10 clk = ~clk;

   kwdt_top dut_i (
      .clk           (clk),
      .rst_n         (rst_n),
      .bus_addr      (bus_addr),
      .bus_we        (bus_we),
      .bus_wdata     (bus_wdata),
      .bus_rdata     (bus_rdata),
      .tick_1us      (tick_1us),
      .memctl_hold   (memctl_hold),
      .wdt_irq       (wdt_irq),
      .sys_rst_out   (sys_rst_out),
      .rst_push_pull (rst_push_pull)
   );

   // {write addr, write data, read addr, expected read, requirement number}
   localparam int NVEC = 14;
   localparam logic [87:0] VEC [NVEC] = '{
      {8'h04, 32'h0000_0005, 8'h04, 32'h0000_0005, 8'd2},  // R2 reload storage
      {8'h0C, 32'hFFFF_FF00, 8'h0C, 32'hFFFF_F010, 8'd4},  // R4 sanitize
      {8'h0C, 32'h0000_0F2E, 8'h0C, 32'h0000_003E, 8'd4},
      {8'h0C, 32'h0000_0000, 8'h0C, 32'h0000_0010, 8'd4},
      {8'h18, 32'hA500_0123, 8'h18, 32'h8000_0123, 8'd9},  // R9 codes
      {8'h18, 32'hA800_0007, 8'h18, 32'hC000_0007, 8'd9},
      {8'h18, 32'h7700_0009, 8'h18, 32'hC000_0009, 8'd9},
      {8'h18, 32'h5A0F_FFFF, 8'h18, 32'h400F_FFFF, 8'd9},
      {8'h18, 32'h8A00_0004, 8'h18, 32'h0000_0004, 8'd9},
      {8'h18, 32'h00F0_0001, 8'h18, 32'h0000_0001, 8'd9},
      {8'h1C, 32'hDEAD_BEEF, 8'h1C, 32'hDEAD_BEEF, 8'd2},
      {8'h08, 32'h0000_1234, 8'h08, 32'h0000_0000, 8'd2},
      {8'h40, 32'h1234_5678, 8'h40, 32'h0000_0000, 8'd2},
      {8'h00, 32'h0000_0055, 8'h00, 32'h014F_B180, 8'd2}
   };

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: got %h expected %h", req, act, exp);
      end
   endtask

   task automatic chk_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
      bus_addr = a;
      #1;
      chk(req, bus_rdata, exp);
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_addr  = a;
      bus_wdata = d;
      bus_we    = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
   endtask

   task automatic tick();
      @(negedge clk);
      tick_1us = 1'b1;
      @(negedge clk);
      tick_1us = 1'b0;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      chk_reg("R1", 8'h00, 32'h014F_B180);
      chk_reg("R1", 8'h04, 32'h014F_B180);
      chk_reg("R1", 8'h0C, 32'h0000_0010);
      chk_reg("R1", 8'h18, 32'h0000_00FF);
      chk("R1", {31'b0, wdt_irq}, 32'h0);
      chk("R1", {31'b0, sys_rst_out}, 32'h1);
      chk("R1", {31'b0, rst_push_pull}, 32'h0);

      for (int i = 0; i < NVEC; i++) begin
         wr(VEC[i][87:80], VEC[i][79:48]);
         chk_reg($sformatf("R%0d vec%0d", VEC[i][7:0], i), VEC[i][47:40], VEC[i][39:8]);
      end

      // R5 enable rise loads and starts; R6 decrement and expiry
      wr(8'h18, 32'h5A00_0002);
      wr(8'h04, 32'h0000_0003);
      wr(8'h0C, 32'h0000_0007);
      chk_reg("R5", 8'h00, 32'h3);
      repeat (3) @(negedge clk);
      chk_reg("R6", 8'h00, 32'h3);
      tick();
      chk_reg("R6", 8'h00, 32'h2);
      tick();
      tick();
      chk("R7", {31'b0, wdt_irq}, 32'h1);
      chk("R8", {31'b0, sys_rst_out}, 32'h0);
      chk_reg("R6", 8'h00, 32'h0);
      tick();
      tick();
      chk("R8", {31'b0, sys_rst_out}, 32'h0);
      tick();
      chk("R8", {31'b0, sys_rst_out}, 32'h1);
      chk_reg("R6", 8'h00, 32'h0);
      chk("R7", {31'b0, wdt_irq}, 32'h1);

      // R3 restart key
      wr(8'h08, 32'hABCD_4756);
      chk_reg("R3", 8'h00, 32'h0);
      chk("R3", {31'b0, wdt_irq}, 32'h1);
      wr(8'h08, 32'hABCD_4755);
      chk_reg("R3", 8'h00, 32'h3);
      chk("R3", {31'b0, wdt_irq}, 32'h0);
      tick();
      wr(8'h0C, 32'h0000_0007);
      chk_reg("R5", 8'h00, 32'h2);
      tick();
      tick();
      chk("R7", {31'b0, wdt_irq}, 32'h1);
      wr(8'h0C, 32'h0000_0006);
      chk("R5", {31'b0, wdt_irq}, 32'h0);
      repeat (3) tick();
      chk("R8", {31'b0, sys_rst_out}, 32'h1);
      chk_reg("R5", 8'h00, 32'h0);

      // R6 reload of zero expires on first tick
      wr(8'h04, 32'h0);
      wr(8'h0C, 32'h0000_0007);
      tick();
      chk("R6", {31'b0, wdt_irq}, 32'h1);
      repeat (3) tick();
      chk("R8", {31'b0, sys_rst_out}, 32'h1);

      // R11 veto
      wr(8'h04, 32'h1);
      wr(8'h08, 32'h0000_4755);
      memctl_hold = 1'b1;
      tick();
      chk_reg("R11", 8'h0C, 32'h0);
      chk("R11", {31'b0, wdt_irq}, 32'h0);
      chk("R11", {31'b0, sys_rst_out}, 32'h1);
      tick();
      chk("R11", {31'b0, sys_rst_out}, 32'h1);
      memctl_hold = 1'b0;

      // R12 restart and expiring tick together
      wr(8'h04, 32'h4);
      wr(8'h0C, 32'h0000_0007);
      repeat (3) tick();
      chk_reg("R12", 8'h00, 32'h1);
      @(negedge clk);
      bus_addr  = 8'h08;
      bus_wdata = 32'h0000_4755;
      bus_we    = 1'b1;
      tick_1us  = 1'b1;
      @(negedge clk);
      bus_we    = 1'b0;
      tick_1us  = 1'b0;
      chk_reg("R12", 8'h00, 32'h4);
      chk("R12", {31'b0, wdt_irq}, 32'h0);
      chk("R12", {31'b0, sys_rst_out}, 32'h1);
      tick();
      chk_reg("R12", 8'h00, 32'h3);

      // R8 active-high, R10 drive type
      wr(8'h18, 32'hA500_0000);
      chk("R8", {31'b0, sys_rst_out}, 32'h0);
      wr(8'h18, 32'hA800_0000);
      chk("R10", {31'b0, rst_push_pull}, 32'h1);
      chk_reg("R9", 8'h18, 32'hC000_0000);
      wr(8'h04, 32'h1);
      wr(8'h08, 32'h0000_4755);
      tick();
      chk("R8", {31'b0, sys_rst_out}, 32'h1);
      chk("R7", {31'b0, wdt_irq}, 32'h1);
      tick();
      chk("R8", {31'b0, sys_rst_out}, 32'h0);
      wr(8'h18, 32'h8A00_0000);
      chk("R10", {31'b0, rst_push_pull}, 32'h0);

      finish_run();
   end

endmodule